// File: doc/BRIEF.md
# Latching Input-Change Detector with Maskable Interrupt

This block watches a byte-wide group of input bits for any change against a stored copy of their last sampled state. Every bit that differs from that copy sets a sticky change flag, so even a pulse that lasts a single clock and then disappears is remembered until the next bus access. A mask register selects which flagged bits may drive an active-low interrupt line; the flags themselves are recorded for every bit whatever the mask holds.

A serial bus controller sits in front of the block and hands it single-cycle events: an address acknowledge for this device (with its transfer direction), the acknowledge of each data byte, the STOP condition and a bus reset. Each address acknowledge resamples the inputs into the stored copy, captures the old flags into a readable byte, clears the live flags and releases the interrupt. During a read, the interrupt is held released until STOP. In a long read, every second byte acknowledge (the end of a port/flag byte pair) resamples again, so a change that the master has already received is not raised again at STOP.

Top module: `edge_watch_irq`

## Requirements
- R1: After reset and a settling time of SYNC_STAGES+1 cycles, the captured flag byte is zero, the interrupt output is high, the mask is all ones, and the snapshot byte equals the input port value.
- R2: A change on an input bit sets that bit's live flag, and the flag stays set after the input returns to its earlier level, including a pulse of one clock.
- R3: Live flags are set for every bit regardless of the mask; a flag on a masked-off bit appears in the captured flag byte but never pulls the interrupt low.
- R4: With no read in progress, a change on an enabled input drives the interrupt low exactly on the fourth rising edge after the input changes (two synchronizer stages, the flag register, the interrupt register).
- R5: On an address acknowledge, in the next cycle the snapshot holds the synchronized inputs, the flag byte holds the flags gathered since the previous resample, the live flags are clear and the interrupt is high.
- R6: From the cycle after a read-direction address acknowledge until STOP, the interrupt stays high; a change left unresampled asserts it on the second rising edge after the STOP pulse.
- R7: In a read, byte acknowledges alternate between the port byte (bit 0 of the pair, no effect on the snapshot) and the flag byte (resample, capture flags, clear flags); a change captured by such a resample does not assert the interrupt after STOP.
- R8: A mask write strobe loads the mask from the write data in the next cycle; a mask bit of 0 stops its input from asserting the interrupt, a 1 lets it.
- R9: A bus reset ends a read hold like STOP but leaves the mask, the captured flag byte and the interrupt level unchanged at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | W | Monitored input bits (asynchronous) |
| adr_ack | input | 1 | Pulse: this device's address byte was acknowledged |
| adr_rd | input | 1 | Direction with adr_ack: 1 read, 0 write |
| byte_ack | input | 1 | Pulse: a data byte was acknowledged |
| stop_det | input | 1 | Pulse: STOP condition seen |
| bus_rst | input | 1 | Pulse: bus reset, aborts the transfer |
| mask_wr | input | 1 | Pulse: load mask from mask_wdata |
| mask_wdata | input | W | Mask value to load |
| flag_byte | output | W | Flags captured at the last resample |
| snap_byte | output | W | Stored snapshot of the inputs |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The hardest situation to reach is a change that lands in the middle of a long read: it must either be raised after STOP or be silently absorbed, depending on whether a byte-pair boundary resampled it first. The bench opens a read, flips an input, then steps byte acknowledges one at a time, checking that only the second one of a pair reloads the snapshot and that no interrupt follows STOP. A second read leaves the change unresampled and checks that the interrupt appears exactly two edges after STOP. A one-clock input pulse, timed between two falling edges, shows that a glitch is kept.

// File: rtl/xdet_pkg.sv
package xdet_pkg;
    // Position inside a byte pair of a read sequence
    typedef enum logic {
        PH_PORT = 1'b0,
        PH_FLAG = 1'b1
    } rd_phase_e;
endpackage

// File: rtl/xdet_sync.sv
module xdet_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/xdet_track.sv
module xdet_track
    import xdet_pkg::*;
#(
    parameter int W      = 8,
    parameter int SETTLE = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic         adr_ack,
    input  logic         adr_rd,
    input  logic         byte_ack,
    input  logic         stop_det,
    input  logic         bus_rst,
    output logic [W-1:0] pend,
    output logic [W-1:0] snap,
    output logic [W-1:0] cap,
    output logic         hold,
    output logic         resamp
);
    localparam int CNT_W = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [W-1:0]     snap;
        logic [W-1:0]     chg;
        logic [W-1:0]     cap;
        logic             hold;
        rd_phase_e        phase;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t st_d, st_q;
    logic [W-1:0] diff;
    logic         settling;

    always_comb begin
        st_d     = st_q;
        diff     = st_q.snap ^ sync_in;
        settling = (st_q.cnt < CNT_W'(SETTLE));
        resamp   = !settling &&
                   (adr_ack || (byte_ack && st_q.hold && st_q.phase == PH_FLAG));

        if (settling) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.snap = sync_in;
            st_d.chg  = '0;
        end else if (resamp) begin
            st_d.snap = sync_in;
            st_d.cap  = st_q.chg | diff;
            st_d.chg  = '0;
        end else begin
            st_d.chg  = st_q.chg | diff;
        end

        if (adr_ack) begin
            st_d.hold  = adr_rd;
            st_d.phase = PH_PORT;
        end else if (stop_det || bus_rst) begin
            st_d.hold  = 1'b0;
            st_d.phase = PH_PORT;
        end else if (byte_ack && st_q.hold) begin
            st_d.phase = (st_q.phase == PH_PORT) ? PH_FLAG : PH_PORT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.snap  <= '0;
            st_q.chg   <= '0;
            st_q.cap   <= '0;
            st_q.hold  <= 1'b0;
            st_q.phase <= PH_PORT;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.chg;
    assign snap = st_q.snap;
    assign cap  = st_q.cap;
    assign hold = st_q.hold;

    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resamp |=> ((st_q.chg & $past(st_q.chg)) == $past(st_q.chg)));
    // R5
    resamp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resamp |=> (st_q.chg == '0));
    // R5
    resamp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resamp |=> (st_q.snap == $past(sync_in)));
    // R7
    pair_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ack && !adr_ack && !settling && st_q.hold && st_q.phase == PH_PORT)
        |=> $stable(st_q.snap));
    // R6
    hold_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !adr_ack) |=> !st_q.hold);
endmodule

// File: rtl/xdet_irq.sv
module xdet_irq #(
    parameter int           W        = 8,
    parameter logic [W-1:0] MASK_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend,
    input  logic         resamp,
    input  logic         hold,
    input  logic         bus_rst,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    output logic         irq_n
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic         irq_n;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.mask  = mask_wr ? mask_wdata : st_q.mask;
        st_d.irq_n = resamp || hold || !(|(pend & st_q.mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask  <= MASK_RST;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = st_q.irq_n;

    // R4
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.irq_n |-> $past(|(pend & st_q.mask)));
    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> st_q.irq_n);
    // R5
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resamp |=> st_q.irq_n);
    // R8
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (st_q.mask == $past(mask_wdata)));
    // R9
    busrst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst && !mask_wr) |=> $stable(st_q.mask));
endmodule

// File: rtl/edge_watch_irq.sv
module edge_watch_irq #(
    parameter int           W           = 8,
    parameter int           SYNC_STAGES = 2,
    parameter logic [W-1:0] MASK_RST    = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port_in,
    input  logic         adr_ack,
    input  logic         adr_rd,
    input  logic         byte_ack,
    input  logic         stop_det,
    input  logic         bus_rst,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] flag_byte,
    output logic [W-1:0] snap_byte,
    output logic         irq_n
);
    localparam int SETTLE = SYNC_STAGES + 1;

    logic [W-1:0] sync_q;
    logic [W-1:0] pend;
    logic         hold;
    logic         resamp;

    xdet_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (port_in),
        .dout (sync_q)
    );

    xdet_track #(.W(W), .SETTLE(SETTLE)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_q),
        .adr_ack (adr_ack),
        .adr_rd  (adr_rd),
        .byte_ack(byte_ack),
        .stop_det(stop_det),
        .bus_rst (bus_rst),
        .pend    (pend),
        .snap    (snap_byte),
        .cap     (flag_byte),
        .hold    (hold),
        .resamp  (resamp)
    );

    xdet_irq #(.W(W), .MASK_RST(MASK_RST)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .resamp    (resamp),
        .hold      (hold),
        .bus_rst   (bus_rst),
        .mask_wr   (mask_wr),
        .mask_wdata(mask_wdata),
        .irq_n     (irq_n)
    );
endmodule

// File: tb/tb_edge_watch_irq.sv
module tb_edge_watch_irq;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] port_in = 8'hA5;
    logic         adr_ack = 1'b0, adr_rd = 1'b0, byte_ack = 1'b0;
    logic         stop_det = 1'b0, bus_rst = 1'b0, mask_wr = 1'b0;
    logic [W-1:0] mask_wdata = '0;
    logic [W-1:0] flag_byte, snap_byte;
    logic         irq_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_watch_irq dut (
        .clk(clk), .rst_n(rst_n), .port_in(port_in),
        .adr_ack(adr_ack), .adr_rd(adr_rd), .byte_ack(byte_ack),
        .stop_det(stop_det), .bus_rst(bus_rst),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .flag_byte(flag_byte), .snap_byte(snap_byte), .irq_n(irq_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic addr(input logic rd);
        adr_ack = 1'b1; adr_rd = rd;
        tick(1);
        adr_ack = 1'b0; adr_rd = 1'b0;
    endtask

    task automatic pulse_byte();
        byte_ack = 1'b1; tick(1); byte_ack = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_det = 1'b1; tick(1); stop_det = 1'b0;
    endtask

    task automatic load_mask(input logic [W-1:0] m);
        mask_wr = 1'b1; mask_wdata = m; tick(1); mask_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flags", flag_byte, 8'h00);
        check("R1 irq", {7'b0, irq_n}, 8'h01);
        check("R1 snap", snap_byte, port_in);
    endtask

    task automatic t_basic();
        port_in = port_in ^ 8'h08;
        tick(3);
        check("R4 irq before 4th edge", {7'b0, irq_n}, 8'h01);
        tick(1);
        check("R4 irq at 4th edge", {7'b0, irq_n}, 8'h00);
        addr(1'b0);
        check("R5 irq released", {7'b0, irq_n}, 8'h01);
        check("R5 flag byte", flag_byte, 8'h08);
        check("R5 snap", snap_byte, port_in);
        tick(3);
        check("R5 flags cleared", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_glitch();
        port_in = port_in ^ 8'h40;
        tick(1);
        port_in = port_in ^ 8'h40;
        tick(6);
        check("R2 glitch irq", {7'b0, irq_n}, 8'h00);
        addr(1'b0);
        check("R2 glitch flag", flag_byte, 8'h40);
        check("R2 snap restored", snap_byte, port_in);
    endtask

    task automatic t_mask();
        load_mask(8'h0F);
        port_in = port_in ^ 8'h80;
        tick(6);
        check("R8 masked bit quiet", {7'b0, irq_n}, 8'h01);
        addr(1'b0);
        check("R3 masked flag kept", flag_byte, 8'h80);
        port_in = port_in ^ 8'h02;
        tick(4);
        check("R8 enabled bit irq", {7'b0, irq_n}, 8'h00);
        addr(1'b0);
        load_mask(8'hFF);
    endtask

    task automatic t_read_defer();
        addr(1'b1);
        port_in = port_in ^ 8'h04;
        tick(6);
        check("R6 irq held in read", {7'b0, irq_n}, 8'h01);
        pulse_stop();
        check("R6 irq 1st edge after stop", {7'b0, irq_n}, 8'h01);
        tick(1);
        check("R6 irq after stop", {7'b0, irq_n}, 8'h00);
        addr(1'b0);
        check("R6 flag byte", flag_byte, 8'h04);
    endtask

    task automatic t_long_read();
        logic [W-1:0] old_v;
        addr(1'b1);
        old_v = port_in;
        port_in = port_in ^ 8'h10;
        tick(4);
        pulse_byte();
        check("R7 port byte ack keeps snap", snap_byte, old_v);
        pulse_byte();
        check("R7 pair end resamples", snap_byte, port_in);
        check("R7 pair end flags", flag_byte, 8'h10);
        pulse_stop();
        tick(3);
        check("R7 no irq after stop", {7'b0, irq_n}, 8'h01);
        addr(1'b0);
        check("R7 flags cleared", flag_byte, 8'h00);
    endtask

    task automatic t_busrst();
        port_in = port_in ^ 8'h20;
        tick(4);
        check("R9 irq set before", {7'b0, irq_n}, 8'h00);
        bus_rst = 1'b1; tick(1); bus_rst = 1'b0;
        check("R9 irq kept", {7'b0, irq_n}, 8'h00);
        check("R9 flag byte kept", flag_byte, 8'h00);
        addr(1'b0);
        check("R9 flags after", flag_byte, 8'h20);
        port_in = port_in ^ 8'h01;
        tick(4);
        check("R9 mask kept", {7'b0, irq_n}, 8'h00);
        addr(1'b0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_basic();
        t_glitch();
        t_mask();
        t_read_defer();
        t_long_read();
        t_busrst();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule